// File: doc/BRIEF.md
# Parallel Flash Command Interpreter

This block is a synthesizable device-side model of a byte-wide NOR flash command interpreter. A host controller drives single-cycle bus writes and reads. Each write carries an address and a data byte, and the block decodes the data byte as a command. Three read views are available: the memory contents, an identifier view, and a status view. Which view a read sees depends on the most recent command accepted.

Erasing a block takes two writes, an erase opcode followed by a confirm byte. Programming a byte also takes two writes, a program opcode followed by the data written at the target address. Both operations run against an internal byte array and hold the device busy for a number of cycles set by parameters. The status register reports ready, erase-error and program-error flags. Two injection inputs force an erase or program to fail, so that the error-recovery paths of a host controller can be exercised.

Top module: `flash_cmd_top`

## Requirements
- R1: After reset, no read data is valid (rd_valid 0, rd_data 0x00). The status register reads 0x80 (ready, no error flags) once status view is selected.
- R2: Writing 0x90 selects identifier view. In this view, offset 0 returns ID_HI, offset 1 returns ID_LO, and every other offset returns 0x00.
- R3: When ID_HI equals 0xB0, the device byte ID_LO moves to offset 2, and offset 1 returns 0x00.
- R4: Writing 0xFF selects array view, where a read returns the stored byte at the address. A write of any opcode outside 0xFF, 0x90, 0x70, 0x50, 0x20 and 0x40 changes nothing.
- R5: Writing 0x70 selects status view. Status bit 7 is ready, bit 5 is the erase error, bit 4 is the program error, and every other bit reads 0.
- R6: Erase is 0x20 followed by the confirm byte 0xD0. The address of the confirm write selects the block of 2^BLK_W bytes, and every byte of that block becomes 0xFF.
- R7: Program is 0x40 followed by a data write. The addressed byte becomes old AND data. If the data has a 1 where the old byte has a 0, status bit 4 is set.
- R8: Program and erase start status view. They keep status bit 7 at 0 for PROG_CYC cycles (program) or max(ERASE_CYC, 2^BLK_W) cycles (erase). Writes arriving while busy are ignored.
- R9: If the write after 0x20 is not 0xD0, the erase is aborted. Status bits 5 and 4 are both set, status view is selected, and the array is not changed.
- R10: Writing 0x50 clears status bits 5 and 4 and leaves the read view as it was.
- R11: If inj_erase_err is high on the confirm write, the erase finishes with bit 5 set and the block unchanged. If inj_prog_err is high on the data write, the program finishes with bit 4 set and the byte unchanged.
- R12: A read returns its data, with rd_valid high, in the cycle after rd_en. If a read and a write fall in the same cycle, the read reflects the view in force before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Bus write strobe |
| rd_en | input | 1 | Bus read strobe |
| addr | input | ADDR_W | Byte address for reads and writes |
| wr_data | input | 8 | Write data or command byte |
| inj_erase_err | input | 1 | Force failure of an erase started this cycle |
| inj_prog_err | input | 1 | Force failure of a program started this cycle |
| rd_data | output | 8 | Registered read data |
| rd_valid | output | 1 | rd_data holds the result of last cycle's read |

## Verification
A command write and a read can be presented in the same cycle. When the write changes the read view, the two collide. The bench provokes this by driving wr_en with 0x70 and rd_en at an array address on one clock edge while the block is in array view. It expects the stored array byte from that read and the status value from the next read. A second overlap, a write landing in a busy period, is provoked by a view-change command issued right after a program starts. It is judged by the status view persisting after the busy period ends.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;
  typedef enum logic [1:0] {MODE_ARRAY, MODE_ID, MODE_STATUS} rd_mode_e;
  typedef enum logic [1:0] {PEND_NONE, PEND_ERASE, PEND_PROG} pend_e;

  localparam logic [7:0] OP_READ_ARRAY = 8'hFF;
  localparam logic [7:0] OP_READ_ID    = 8'h90;
  localparam logic [7:0] OP_READ_STAT  = 8'h70;
  localparam logic [7:0] OP_CLR_STAT   = 8'h50;
  localparam logic [7:0] OP_ERASE      = 8'h20;
  localparam logic [7:0] OP_CONFIRM    = 8'hD0;
  localparam logic [7:0] OP_PROGRAM    = 8'h40;
endpackage

// File: rtl/flash_cmd_array.sv
module flash_cmd_array #(
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [7:0]        wdata,
  input  logic [ADDR_W-1:0] raddr_a,
  output logic [7:0]        rdata_a,
  input  logic [ADDR_W-1:0] raddr_b,
  output logic [7:0]        rdata_b
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata_a = mem[raddr_a];
  assign rdata_b = mem[raddr_b];
endmodule

// File: rtl/flash_cmd_decode.sv
module flash_cmd_decode
  import flash_cmd_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     wr_en,
  input  logic [7:0] wr_data,
  input  logic     busy,
  input  logic     op_done,
  input  logic     done_ers_err,
  input  logic     done_prg_err,
  output rd_mode_e mode,
  output logic     ers_err,
  output logic     prg_err,
  output logic     start_erase,
  output logic     start_prog
);
  rd_mode_e mode_q, mode_d;
  pend_e    pend_q, pend_d;
  logic     ers_q, ers_d, prg_q, prg_d;
  logic     accept;

  assign accept = wr_en && !busy;

  always_comb begin
    mode_d      = mode_q;
    pend_d      = pend_q;
    ers_d       = ers_q;
    prg_d       = prg_q;
    start_erase = 1'b0;
    start_prog  = 1'b0;
    if (accept) begin
      case (pend_q)
        PEND_ERASE: begin
          pend_d = PEND_NONE;
          mode_d = MODE_STATUS;
          if (wr_data == OP_CONFIRM) begin
            start_erase = 1'b1;
          end else begin
            ers_d = 1'b1;
            prg_d = 1'b1;
          end
        end
        PEND_PROG: begin
          pend_d     = PEND_NONE;
          mode_d     = MODE_STATUS;
          start_prog = 1'b1;
        end
        default: begin
          case (wr_data)
            OP_READ_ARRAY: mode_d = MODE_ARRAY;
            OP_READ_ID:    mode_d = MODE_ID;
            OP_READ_STAT:  mode_d = MODE_STATUS;
            OP_CLR_STAT: begin
              ers_d = 1'b0;
              prg_d = 1'b0;
            end
            OP_ERASE:      pend_d = PEND_ERASE;
            OP_PROGRAM:    pend_d = PEND_PROG;
            default:       ;
          endcase
        end
      endcase
    end
    if (op_done) begin
      ers_d = ers_d | done_ers_err;
      prg_d = prg_d | done_prg_err;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= MODE_ARRAY;
      pend_q <= PEND_NONE;
      ers_q  <= 1'b0;
      prg_q  <= 1'b0;
    end else begin
      mode_q <= mode_d;
      pend_q <= pend_d;
      ers_q  <= ers_d;
      prg_q  <= prg_d;
    end
  end

  assign mode    = mode_q;
  assign ers_err = ers_q;
  assign prg_err = prg_q;

  // R9
  abort_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && pend_q == PEND_ERASE && wr_data != OP_CONFIRM) |=> (ers_q && prg_q));

  // R10
  clear_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && pend_q == PEND_NONE && wr_data == OP_CLR_STAT) |=> (!ers_q && !prg_q));

  // R8
  busy_view_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (mode_q == MODE_STATUS));
endmodule

// File: rtl/flash_op_engine.sv
module flash_op_engine #(
  parameter int ADDR_W    = 10,
  parameter int BLK_W     = 8,
  parameter int ERASE_CYC = 300,
  parameter int PROG_CYC  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_erase,
  input  logic              start_prog,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wr_data,
  input  logic              inj_erase_err,
  input  logic              inj_prog_err,
  input  logic [7:0]        cur_byte,
  output logic [ADDR_W-1:0] tgt_addr,
  output logic              busy,
  output logic              op_done,
  output logic              done_ers_err,
  output logic              done_prg_err,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [7:0]        mem_wdata
);
  localparam int BLK_BYTES = 1 << BLK_W;
  localparam int ERASE_LEN = (ERASE_CYC > BLK_BYTES) ? ERASE_CYC : BLK_BYTES;
  localparam int MAX_LEN   = (ERASE_LEN > PROG_CYC) ? ERASE_LEN : PROG_CYC;
  localparam int CNT_W     = $clog2(MAX_LEN) + 1;

  logic              busy_q, is_erase_q, inj_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [ADDR_W-1:0] tgt_q;
  logic [7:0]        data_q;
  logic              last, start, cnt_en;

  assign start  = start_erase || start_prog;
  assign last   = busy_q && (cnt_q == (is_erase_q ? CNT_W'(ERASE_LEN - 1) : CNT_W'(PROG_CYC - 1)));
  assign cnt_en = busy_q && !last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q     <= 1'b0;
      is_erase_q <= 1'b0;
      inj_q      <= 1'b0;
      cnt_q      <= '0;
      tgt_q      <= '0;
      data_q     <= '0;
    end else begin
      if (start) begin
        busy_q     <= 1'b1;
        is_erase_q <= start_erase;
        inj_q      <= start_erase ? inj_erase_err : inj_prog_err;
        cnt_q      <= '0;
        tgt_q      <= addr;
        data_q     <= wr_data;
      end else if (last) begin
        busy_q <= 1'b0;
      end else if (cnt_en) begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  always_comb begin
    mem_we    = 1'b0;
    mem_addr  = tgt_q;
    mem_wdata = cur_byte & data_q;
    if (busy_q && !inj_q) begin
      if (is_erase_q) begin
        mem_addr  = {tgt_q[ADDR_W-1:BLK_W], cnt_q[BLK_W-1:0]};
        mem_wdata = 8'hFF;
        mem_we    = (cnt_q < CNT_W'(BLK_BYTES));
      end else begin
        mem_we = last;
      end
    end
  end

  assign tgt_addr     = tgt_q;
  assign busy         = busy_q;
  assign op_done      = last;
  assign done_ers_err = last && is_erase_q && inj_q;
  assign done_prg_err = last && !is_erase_q && (inj_q || ((data_q & ~cur_byte) != 8'h00));

  // R8
  start_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> !busy_q);

  // R6
  erase_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we && is_erase_q) |-> (mem_wdata == 8'hFF));

  // R7
  prog_clear_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we && !is_erase_q) |-> ((mem_wdata & ~cur_byte) == 8'h00));

  // R11
  inject_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && inj_q) |-> !mem_we);
endmodule

// File: rtl/flash_cmd_top.sv
module flash_cmd_top
  import flash_cmd_pkg::*;
#(
  parameter int         ADDR_W    = 10,
  parameter int         BLK_W     = 8,
  parameter int         ERASE_CYC = 300,
  parameter int         PROG_CYC  = 4,
  parameter logic [7:0] ID_HI     = 8'h89,
  parameter logic [7:0] ID_LO     = 8'hA6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wr_data,
  input  logic              inj_erase_err,
  input  logic              inj_prog_err,
  output logic [7:0]        rd_data,
  output logic              rd_valid
);
  rd_mode_e          mode;
  logic              ers_err, prg_err, start_erase, start_prog;
  logic              busy, op_done, done_ers_err, done_prg_err;
  logic              mem_we;
  logic [ADDR_W-1:0] mem_addr, tgt_addr;
  logic [7:0]        mem_wdata, arr_byte, cur_byte, status, rd_next, rd_data_q;
  logic              rd_valid_q, id_lo_hit;

  flash_cmd_decode u_decode (
    .clk, .rst_n, .wr_en, .wr_data, .busy, .op_done, .done_ers_err, .done_prg_err,
    .mode, .ers_err, .prg_err, .start_erase, .start_prog
  );

  flash_op_engine #(
    .ADDR_W(ADDR_W), .BLK_W(BLK_W), .ERASE_CYC(ERASE_CYC), .PROG_CYC(PROG_CYC)
  ) u_engine (
    .clk, .rst_n, .start_erase, .start_prog, .addr, .wr_data, .inj_erase_err,
    .inj_prog_err, .cur_byte, .tgt_addr, .busy, .op_done, .done_ers_err,
    .done_prg_err, .mem_we, .mem_addr, .mem_wdata
  );

  flash_cmd_array #(.ADDR_W(ADDR_W)) u_array (
    .clk, .we(mem_we), .waddr(mem_addr), .wdata(mem_wdata),
    .raddr_a(addr), .rdata_a(arr_byte), .raddr_b(tgt_addr), .rdata_b(cur_byte)
  );

  generate
    if (ID_HI == 8'hB0) begin : g_wide_id
      assign id_lo_hit = (addr == ADDR_W'(2));
    end else begin : g_narrow_id
      assign id_lo_hit = (addr == ADDR_W'(1));
    end
  endgenerate

  assign status = {!busy, 1'b0, ers_err, prg_err, 4'b0000};

  always_comb begin
    case (mode)
      MODE_ID: begin
        if (addr == '0)     rd_next = ID_HI;
        else if (id_lo_hit) rd_next = ID_LO;
        else                rd_next = 8'h00;
      end
      MODE_STATUS: rd_next = status;
      default:     rd_next = arr_byte;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_valid_q <= 1'b0;
      rd_data_q  <= 8'h00;
    end else begin
      rd_valid_q <= rd_en;
      if (rd_en) rd_data_q <= rd_next;
    end
  end

  assign rd_data  = rd_data_q;
  assign rd_valid = rd_valid_q;

  // R12
  read_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |=> rd_valid);

  // R8
  busy_not_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && busy) |=> !rd_data[7]);
endmodule

// File: tb/tb_flash_cmd_top.sv
module tb_flash_cmd_top;
  localparam int ADDR_W = 10;
  localparam int ERASE_CYC = 300;

  logic clk = 1'b0;
  logic rst_n, wr_en, rd_en, inj_erase_err, inj_prog_err;
  logic [ADDR_W-1:0] addr;
  logic [7:0] wr_data, rd_data, rd_data_b;
  logic rd_valid, rd_valid_b;

  int checks = 0;
  int errors = 0;

  typedef struct { logic [7:0] exp; string tag; } exp_t;
  exp_t sb[$];

  always #4 clk = ~clk;

  flash_cmd_top #(.ADDR_W(ADDR_W), .ERASE_CYC(ERASE_CYC)) dut (
    .clk, .rst_n, .wr_en, .rd_en, .addr, .wr_data, .inj_erase_err, .inj_prog_err,
    .rd_data, .rd_valid
  );

  flash_cmd_top #(.ADDR_W(ADDR_W), .ERASE_CYC(ERASE_CYC), .ID_HI(8'hB0), .ID_LO(8'hD4)) dut_b (
    .clk, .rst_n, .wr_en, .rd_en, .addr, .wr_data, .inj_erase_err, .inj_prog_err,
    .rd_data(rd_data_b), .rd_valid(rd_valid_b)
  );

  function automatic void chk(input bit ok, input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
    end
  endfunction

  // monitor: pop one expectation per valid read
  always @(negedge clk) begin
    if (rst_n === 1'b1 && rd_valid === 1'b1) begin
      if (sb.size() == 0) begin
        chk(1'b0, "R12 unexpected rd_valid", rd_data, 8'h00);
      end else begin
        exp_t e;
        e = sb.pop_front();
        chk(rd_data === e.exp, e.tag, rd_data, e.exp);
      end
    end
  end

  task automatic wr(input logic [ADDR_W-1:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [ADDR_W-1:0] a, input logic [7:0] e, input string tag);
    @(negedge clk);
    rd_en = 1'b1; addr = a;
    sb.push_back('{exp: e, tag: tag});
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic rd2(input logic [ADDR_W-1:0] a, input logic [7:0] e, input logic [7:0] eb, input string tag);
    @(negedge clk);
    rd_en = 1'b1; addr = a;
    sb.push_back('{exp: e, tag: tag});
    @(negedge clk);
    rd_en = 1'b0;
    chk(rd_valid_b === 1'b1 && rd_data_b === eb, "R3 second device id", rd_data_b, eb);
  endtask

  task automatic wr_rd(input logic [ADDR_W-1:0] a, input logic [7:0] d, input logic [7:0] e, input string tag);
    @(negedge clk);
    wr_en = 1'b1; rd_en = 1'b1; addr = a; wr_data = d;
    sb.push_back('{exp: e, tag: tag});
    @(negedge clk);
    wr_en = 1'b0; rd_en = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not complete");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; rd_en = 1'b0; addr = '0; wr_data = 8'h00;
    inj_erase_err = 1'b0; inj_prog_err = 1'b0;
    idle(3);
    rst_n = 1'b1;
    idle(1);
    chk(rd_valid === 1'b0 && rd_data === 8'h00, "R1 reset outputs", rd_data, 8'h00);
    wr(0, 8'h70);
    rd(0, 8'h80, "R1 R5 status after reset");

    // identifier view
    wr(0, 8'h90);
    rd2(0, 8'h89, 8'hB0, "R2 manufacturer byte");
    rd2(1, 8'hA6, 8'h00, "R2 device byte at offset 1");
    rd2(2, 8'h00, 8'hD4, "R2 offset 2 reads zero");
    rd(3, 8'h00, "R2 other offset");

    // erase block 1
    wr(10'h100, 8'h20);
    wr(10'h180, 8'hD0);
    rd(0, 8'h00, "R8 busy during erase");
    idle(ERASE_CYC + 10);
    rd(0, 8'h80, "R6 erase done ready");
    wr(0, 8'hFF);
    rd(10'h100, 8'hFF, "R6 erased first byte");
    rd(10'h17F, 8'hFF, "R6 erased middle byte");
    rd(10'h1FF, 8'hFF, "R6 erased last byte");

    // unknown opcode
    wr(0, 8'h12);
    rd(10'h100, 8'hFF, "R4 unknown opcode ignored");

    // program
    wr(10'h105, 8'h40);
    wr(10'h105, 8'h5A);
    rd(0, 8'h00, "R8 busy during program");
    idle(8);
    rd(0, 8'h80, "R7 program done no error");
    wr(0, 8'hFF);
    rd(10'h105, 8'h5A, "R7 programmed byte");
    rd(10'h104, 8'hFF, "R7 neighbour untouched");

    // program trying to set bits
    wr(10'h105, 8'h40);
    wr(10'h105, 8'hA5);
    idle(8);
    rd(0, 8'h90, "R7 set-bit attempt flags error");
    wr(0, 8'hFF);
    rd(10'h105, 8'h00, "R7 result is old AND data");

    // clear
    wr(0, 8'h50);
    rd(10'h105, 8'h00, "R10 clear keeps array view");
    wr(0, 8'h70);
    rd(0, 8'h80, "R10 error bits cleared");

    // aborted erase
    wr(10'h100, 8'h20);
    wr(10'h100, 8'h33);
    rd(0, 8'hB0, "R9 abort sets both error bits");
    wr(0, 8'hFF);
    rd(10'h105, 8'h00, "R9 block not erased");
    wr(0, 8'h50);
    wr(0, 8'h70);
    rd(0, 8'h80, "R10 cleared after abort");

    // write during busy ignored
    wr(10'h106, 8'h40);
    wr(10'h106, 8'hF0);
    wr(0, 8'hFF);
    idle(8);
    rd(0, 8'h80, "R8 write while busy ignored");
    wr(0, 8'hFF);
    rd(10'h106, 8'hF0, "R8 program completed");

    // injected erase failure
    wr(10'h100, 8'h20);
    inj_erase_err = 1'b1;
    wr(10'h100, 8'hD0);
    inj_erase_err = 1'b0;
    idle(ERASE_CYC + 10);
    rd(0, 8'hA0, "R11 injected erase error");
    wr(0, 8'hFF);
    rd(10'h105, 8'h00, "R11 block unchanged");

    // injected program failure
    wr(0, 8'h50);
    wr(10'h104, 8'h40);
    inj_prog_err = 1'b1;
    wr(10'h104, 8'h0F);
    inj_prog_err = 1'b0;
    idle(8);
    rd(0, 8'h90, "R11 injected program error");
    wr(0, 8'hFF);
    rd(10'h104, 8'hFF, "R11 byte unchanged");
    wr(0, 8'h50);
    wr(0, 8'h70);
    rd(0, 8'h80, "R10 cleared after injection");

    // read and write in the same cycle
    wr(0, 8'hFF);
    wr_rd(10'h104, 8'h70, 8'hFF, "R12 same-cycle read sees old view");
    rd(10'h104, 8'h80, "R12 next read sees new view");

    idle(5);
    chk(sb.size() == 0, "R12 outstanding reads", 8'(sb.size()), 8'h00);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule